// File: doc/BRIEF.md
# Two-Level Frame Priority Classifier

This block gives every received frame a priority of high or low, using two fields already pulled out of the frame's header. The first field is the IPv4 type-of-service byte, whose upper six bits form a differentiated-services code point. The code point is decoded into one of 64 positions, and the bit at that position in a programmable 64-bit map sets the priority. The second field is the 3-bit user priority from a VLAN tag. It is compared against a programmable threshold. Each method can be switched on or off for each ingress port.

A header parser presents one frame's fields on the cycle it raises `in_valid`. One clock later the block raises `out_valid` for one cycle and drives the result on `out_high`. A small two-state controller holds the result. It sits in `ST_IDLE` when it has nothing to report and in `ST_RESULT` during the cycle after an accepted frame. The transition IDLE→RESULT and the transition RESULT→RESULT both occur when `in_valid` is high. The transition RESULT→IDLE and the transition IDLE→IDLE both occur when `in_valid` is low. Frames can therefore arrive on back-to-back cycles.

Top module: `prio_classifier`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high during the following cycle. When `in_valid` is low at a rising edge, `out_valid` is low during the following cycle.
- R2: The code point is `tos_byte[7:2]`. The bits `tos_byte[1:0]` have no effect on the result.
- R3: Map bit `dscp_map[k]` belongs to code point k. A 1 votes high and a 0 votes low.
- R4: The map method applies only when `tos_valid` is high and `dscp_en[p]` is high, where p is the value of `in_port`. Bit p of `dscp_en` belongs to port p.
- R5: For a tagged frame, the tag method votes high when `tag_pri >= pri_threshold` (unsigned). Otherwise it votes low. A threshold of 0 makes every tagged frame vote high.
- R6: The tag method applies only when `tag_present` is high and `tag_en[p]` is high, where p is the value of `in_port`.
- R7: When both methods apply, the frame is high if either method votes high.
- R8: A frame for which no method applies is low. An `in_port` value of NUM_PORTS or more enables no method.
- R9: `out_high` is low whenever `out_valid` is low. After reset, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Frame header fields present this cycle |
| in_port | input | PORT_W (3) | Ingress port number |
| tos_valid | input | 1 | Frame carries an IPv4 TOS byte |
| tos_byte | input | 8 | IPv4 type-of-service byte |
| tag_present | input | 1 | Frame carries a VLAN tag |
| tag_pri | input | 3 | Tag user priority |
| dscp_map | input | 64 | Map from code point to priority; bit k is for code point k |
| pri_threshold | input | 3 | Lowest tag priority that is classed high |
| dscp_en | input | NUM_PORTS (5) | Per-port enable for the map method |
| tag_en | input | NUM_PORTS (5) | Per-port enable for the tag method |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_high | output | 1 | 1 means high priority, 0 means low |

## Verification
The assertions check on every cycle that the one-cycle strobe timing holds in both directions, that a high result never appears without its strobe, that an enabled tagged frame at or above the threshold always comes out high, and that a frame with neither field comes out low. Other behaviours are shown only by the bench's scenarios. These are the selection of a single map bit by the code point, the fact that the two low TOS bits are ignored, the per-port gating of each method, the OR of the two votes, and the handling of out-of-range port numbers. The bench covers them with directed cases at code points 0 and 63, thresholds 0 and 7, and disabled or invalid ports, together with seeded random frames.

// File: rtl/prio_cls_pkg.sv
package prio_cls_pkg;
    localparam int unsigned CODE_W = 6;
    localparam int unsigned MAP_W  = 1 << CODE_W;
    localparam int unsigned PRI_W  = 3;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } cls_state_e;
endpackage

// File: rtl/prio_cls_port_enables.sv
module prio_cls_port_enables #(
    parameter int unsigned NUM_PORTS = 5,
    parameter int unsigned PORT_W    = 3
) (
    input  logic [PORT_W-1:0]    port,
    input  logic [NUM_PORTS-1:0] dscp_en,
    input  logic [NUM_PORTS-1:0] tag_en,
    output logic                 dscp_on,
    output logic                 tag_on
);
    logic [NUM_PORTS-1:0] hit;

    // One-hot port match; a port number with no match enables nothing.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_match
        assign hit[p] = (port == PORT_W'(p));
    end

    assign dscp_on = |(hit & dscp_en);
    assign tag_on  = |(hit & tag_en);
endmodule

// File: rtl/prio_cls_dscp_lookup.sv
module prio_cls_dscp_lookup
    import prio_cls_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [MAP_W-1:0]  map,
    input  logic              apply,
    output logic              vote_high
);
    logic [MAP_W-1:0] onehot;

    // Full decode of the code point, then mask against the map.
    always_comb begin
        onehot       = '0;
        onehot[code] = 1'b1;
    end

    assign vote_high = apply & (|(onehot & map));
endmodule

// File: rtl/prio_cls_tag_compare.sv
module prio_cls_tag_compare
    import prio_cls_pkg::*;
(
    input  logic [PRI_W-1:0] pri,
    input  logic [PRI_W-1:0] threshold,
    input  logic             apply,
    output logic             vote_high
);
    assign vote_high = apply & (pri >= threshold);
endmodule

// File: rtl/prio_classifier.sv
module prio_classifier
    import prio_cls_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 5,
    parameter int unsigned PORT_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [PORT_W-1:0]    in_port,
    input  logic                 tos_valid,
    input  logic [7:0]           tos_byte,
    input  logic                 tag_present,
    input  logic [2:0]           tag_pri,
    input  logic [63:0]          dscp_map,
    input  logic [2:0]           pri_threshold,
    input  logic [NUM_PORTS-1:0] dscp_en,
    input  logic [NUM_PORTS-1:0] tag_en,
    output logic                 out_valid,
    output logic                 out_high
);
    cls_state_e state_q, state_d;
    logic       high_q;
    logic       dscp_on, tag_on;
    logic       dscp_vote, tag_vote;
    logic       unused_tos_lsbs;

    // The two low TOS bits carry no part of the code point (R2).
    assign unused_tos_lsbs = ^tos_byte[1:0];

    prio_cls_port_enables #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W)
    ) u_enables (
        .port    (in_port),
        .dscp_en (dscp_en),
        .tag_en  (tag_en),
        .dscp_on (dscp_on),
        .tag_on  (tag_on)
    );

    prio_cls_dscp_lookup u_dscp (
        .code      (tos_byte[7:2]),
        .map       (dscp_map),
        .apply     (tos_valid & dscp_on),
        .vote_high (dscp_vote)
    );

    prio_cls_tag_compare u_tag (
        .pri       (tag_pri),
        .threshold (pri_threshold),
        .apply     (tag_present & tag_on),
        .vote_high (tag_vote)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            high_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (in_valid) begin
                high_q <= dscp_vote | tag_vote;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                out_valid = 1'b0;
                out_high  = 1'b0;
            end
            ST_RESULT: begin
                out_valid = 1'b1;
                out_high  = high_q;
            end
            default: begin
                out_valid = 1'b0;
                out_high  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/prio_cls_checker.sv
module prio_cls_checker #(
    parameter int unsigned NUM_PORTS = 5,
    parameter int unsigned PORT_W    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [PORT_W-1:0]    in_port,
    input logic                 tos_valid,
    input logic                 tag_present,
    input logic [2:0]           tag_pri,
    input logic [2:0]           pri_threshold,
    input logic [NUM_PORTS-1:0] tag_en,
    input logic                 out_valid,
    input logic                 out_high
);
    logic port_tag_on;

    always_comb begin
        port_tag_on = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (in_port == PORT_W'(p)) port_tag_on = tag_en[p];
        end
    end

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1

    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1

    AST_HIGH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_high |-> out_valid); // R9

    AST_TAG_AT_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tag_present && port_tag_on && (tag_pri >= pri_threshold))
        |=> out_high); // R5

    AST_NO_METHOD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !tos_valid && !tag_present) |=> !out_high); // R8
endmodule

bind prio_classifier prio_cls_checker #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
) u_chk (.*);

// File: tb/tb_prio_classifier.sv
module tb_prio_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 5;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [PW-1:0] in_port = '0;
    logic          tos_valid = 1'b0;
    logic [7:0]    tos_byte = '0;
    logic          tag_present = 1'b0;
    logic [2:0]    tag_pri = '0;
    logic [63:0]   dscp_map = '0;
    logic [2:0]    pri_threshold = '0;
    logic [NP-1:0] dscp_en = '0;
    logic [NP-1:0] tag_en = '0;
    logic          out_valid;
    logic          out_high;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    prio_classifier #(.NUM_PORTS(NP), .PORT_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port),
        .tos_valid(tos_valid), .tos_byte(tos_byte), .tag_present(tag_present),
        .tag_pri(tag_pri), .dscp_map(dscp_map), .pri_threshold(pri_threshold),
        .dscp_en(dscp_en), .tag_en(tag_en), .out_valid(out_valid), .out_high(out_high)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic bit model();
        bit de, te, vd, vt;
        de = (int'(in_port) < NP) ? dscp_en[in_port] : 1'b0;
        te = (int'(in_port) < NP) ? tag_en[in_port] : 1'b0;
        vd = tos_valid && de && dscp_map[tos_byte[7:2]];
        vt = tag_present && te && (tag_pri >= pri_threshold);
        return vd || vt;
    endfunction

    task automatic check(input bit act, input bit exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Drive a frame at a falling edge, let one rising edge pass, check at the next falling edge.
    task automatic frame(input logic [PW-1:0] p, input bit tv, input logic [7:0] tb,
                         input bit tp, input logic [2:0] pr, input string req);
        bit exp;
        in_valid = 1'b1; in_port = p; tos_valid = tv; tos_byte = tb;
        tag_present = tp; tag_pri = pr;
        exp = model();
        @(posedge clk);
        @(negedge clk);
        check(out_valid, 1'b1, "R1");
        check(out_high, exp, req);
        in_valid = 1'b0;
    endtask

    task automatic idle_check();
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(out_valid, 1'b0, "R1");
        check(out_high, 1'b0, "R9");
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        check(out_valid, 1'b0, "R9 reset");
        check(out_high, 1'b0, "R9 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid, 1'b0, "R9");

        // R3: single map bit at code point 0 and 63
        dscp_en = '1; tag_en = '0; pri_threshold = 3'd7;
        dscp_map = 64'h1;
        frame(3'd0, 1, 8'h00, 0, 0, "R3 code0");
        frame(3'd0, 1, 8'h04, 0, 0, "R3 code1");
        dscp_map = 64'h8000_0000_0000_0000;
        frame(3'd1, 1, 8'hFC, 0, 0, "R3 code63");
        frame(3'd1, 1, 8'hF8, 0, 0, "R3 code62");
        // R2: low TOS bits ignored
        frame(3'd1, 1, 8'hFF, 0, 0, "R2 lsbs set");
        dscp_map = 64'h1;
        frame(3'd2, 1, 8'h03, 0, 0, "R2 lsbs code0");
        // R4: tos_valid low, port disabled
        dscp_map = '1;
        frame(3'd2, 0, 8'h00, 0, 0, "R4 tos invalid");
        dscp_en = 5'b11011;
        frame(3'd2, 1, 8'h10, 0, 0, "R4 port off");
        frame(3'd3, 1, 8'h10, 0, 0, "R4 port on");
        idle_check();
        // R5: threshold corners
        dscp_en = '0; tag_en = '1;
        pri_threshold = 3'd0;
        frame(3'd4, 0, 8'h00, 1, 3'd0, "R5 thr0");
        pri_threshold = 3'd7;
        frame(3'd4, 0, 8'h00, 1, 3'd6, "R5 below");
        frame(3'd4, 0, 8'h00, 1, 3'd7, "R5 equal");
        // R6
        frame(3'd4, 0, 8'h00, 0, 3'd7, "R6 no tag");
        tag_en = 5'b01111;
        frame(3'd4, 0, 8'h00, 1, 3'd7, "R6 port off");
        // R7: either vote high
        dscp_en = '1; tag_en = '1; dscp_map = '0; pri_threshold = 3'd2;
        frame(3'd0, 1, 8'h20, 1, 3'd5, "R7 tag only high");
        dscp_map = '1;
        frame(3'd0, 1, 8'h20, 1, 3'd1, "R7 map only high");
        dscp_map = '0;
        frame(3'd0, 1, 8'h20, 1, 3'd1, "R7 both low");
        // R8
        dscp_map = '1; pri_threshold = 3'd0;
        frame(3'd1, 0, 8'hFF, 0, 3'd7, "R8 no method");
        frame(3'd6, 1, 8'hFF, 1, 3'd7, "R8 port out of range");
        idle_check();

        // Random frames, mixed with idle gaps
        for (int i = 0; i < 400; i++) begin
            dscp_map = {$urandom, $urandom};
            pri_threshold = 3'($urandom);
            dscp_en = NP'($urandom);
            tag_en = NP'($urandom);
            frame(PW'($urandom % 6), 1'($urandom), 8'($urandom),
                  1'($urandom), 3'($urandom), "R7 random");
            if ($urandom % 4 == 0) idle_check();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule